// File: doc/BRIEF.md
# Fuse Shadow Register Bank with Access Locks

This block keeps a register-bus-visible copy ("shadow") of every word of a small one-time-programmable fuse array. Software reads the shadows at a fixed base with a fixed stride. It refreshes them by setting a reload bit through a set-alias of the control register. A reload engine then walks the fuse array from the lowest word to the highest. Each fuse read has a configurable latency, and a programmable strobe time is added per word. Each fuse word is copied into its shadow in turn.

Fuse word 0 is a lock word. Whenever a reload copies it, it replaces the lock state that guards the shadows, in groups of `NWORDS/16` consecutive words. A read of a read-locked shadow returns the marker `0xBADABADA`. A write to a write-locked shadow is dropped. A write to any shadow while a reload is running is also dropped. Every such violation sets a sticky error flag. While that flag is set, reload requests are refused. Software clears the flag through a clear-alias of the control register.

The reload engine is a five-state machine. From IDLE, an accepted request moves it to ISSUE. It then always goes from ISSUE to WAIT. WAIT moves to DWELL once fuse data is back and the strobe is non-zero, or straight to STORE when the strobe is zero. DWELL moves to STORE when its count runs out. STORE returns to ISSUE for the next word, or to IDLE after the last word.

Top module: `shlk_shadow_bank`

## Requirements
- R1: After reset, all three control bits read 0: BUSY is bit 8, ERROR is bit 9 and RELOAD is bit 10. Every shadow reads 0, no word is locked, and the timing register reads its reset strobe value of 2.
- R2: Address map (byte offsets):
  - 0x000 is the control register. 0x004 is its set alias and 0x008 its clear alias, and both aliases read back the control word.
  - 0x010 holds the strobe count in bits [5:0].
  - Shadow i sits at 0x400 + 0x10·i.
  - Any other offset reads 0, including a misaligned offset inside the shadow window.
- R3: Writing bit 10 to the set alias starts a reload when the bank is idle and ERROR is clear. BUSY and RELOAD both read 1 until the last word has been copied, then both read 0. Words are copied in ascending order.
- R4: After a reload, shadow 0 holds the lock word (default 0x0024000A). Shadow i ≥ 1 holds 0xF00D0000 + 257·i.
- R5: Each word of a reload takes FUSE_LAT + strobe + 2 clocks. With the default FUSE_LAT of 1 and a strobe of 0, a 128-word reload keeps BUSY set for 384 clocks, and every unit of strobe adds NWORDS clocks.
- R6: Lock bits come from the lock word:
  - Bit g (0..15) read-locks group g, where group = i / (NWORDS/16).
  - Bit 16+g write-locks group g.
  - Locks change only when a reload copies word 0. A bus write to shadow 0 does not alter them.
- R7: A write to an unlocked shadow while idle stores the data. Reading it back returns that value, and ERROR is unchanged.
- R8: A write to any shadow during a reload leaves every shadow as the reload sets it, and sets ERROR.
- R9: A write to a write-locked shadow leaves it unchanged and sets ERROR.
- R10: A read of a read-locked shadow returns 0xBADABADA and sets ERROR. A read of an unlocked shadow never changes ERROR.
- R11: ERROR is sticky and stays set until bit 9 is written to the clear alias. While ERROR is set, reload requests are refused. Writing bit 9 to the set alias has no effect, and neither does any write to the control base offset.
- R12: Every read request is answered by `bus_rvalid` exactly one clock later. Write requests produce no `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one clock after a read request |

## Verification
The reload engine and the bus write path can want the same shadow storage in the same cycle. The bench provokes this by starting a reload and immediately issuing shadow writes while BUSY is still set. It then judges the outcome by reading every shadow back against the fuse image and by checking that ERROR has latched. The second collision is between a reload request and a pending ERROR. It is provoked by a set-alias write while ERROR is set, and judged by reading the control word in the following cycles and confirming BUSY stays clear.

// File: rtl/shlk_pkg.sv
package shlk_pkg;

    localparam int CTRL_BUSY_BIT   = 8;
    localparam int CTRL_ERR_BIT    = 9;
    localparam int CTRL_RELOAD_BIT = 10;

    localparam int OFS_CTRL     = 'h000;
    localparam int OFS_CTRL_SET = 'h004;
    localparam int OFS_CTRL_CLR = 'h008;
    localparam int OFS_TIMING   = 'h010;
    localparam int OFS_SHADOW   = 'h400;
    localparam int SHADOW_SHIFT = 4;   // 0x10 bytes between shadows

    localparam logic [31:0] LOCKED_MARKER = 32'hBADA_BADA;

    typedef enum logic [2:0] {
        RL_IDLE,
        RL_ISSUE,
        RL_WAIT,
        RL_DWELL,
        RL_STORE
    } reload_state_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_SET,
        ACC_CLR,
        ACC_TIMING,
        ACC_SHADOW
    } acc_kind_e;

endpackage

// File: rtl/shlk_fuse_model.sv
module shlk_fuse_model #(
    parameter int          NWORDS    = 128,
    parameter int          IDX_W     = $clog2(NWORDS),
    parameter int          LAT       = 1,
    parameter logic [31:0] LOCK_WORD = 32'h0024_000A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [31:0]      rd_data
);

    // Fuse contents are computed: word 0 carries the lock bits.
    function automatic logic [31:0] rom_word(logic [IDX_W-1:0] i);
        if (i == '0) return LOCK_WORD;
        return 32'hF00D_0000 + 32'(i) * 32'd257;
    endfunction

    logic        vld_q [LAT];
    logic [31:0] dat_q [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            dat_q[0] <= '0;
        end else begin
            vld_q[0] <= rd_en;
            dat_q[0] <= rom_word(rd_idx);
        end
    end

    for (genvar s = 1; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
                dat_q[s] <= '0;
            end else begin
                vld_q[s] <= vld_q[s-1];
                dat_q[s] <= dat_q[s-1];
            end
        end
    end

    assign rd_valid = vld_q[LAT-1];
    assign rd_data  = dat_q[LAT-1];

endmodule

// File: rtl/shlk_reload_fsm.sv
module shlk_reload_fsm
    import shlk_pkg::*;
#(
    parameter int NWORDS   = 128,
    parameter int IDX_W    = $clog2(NWORDS),
    parameter int STROBE_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [STROBE_W-1:0] strobe,
    input  logic                fuse_valid,
    input  logic [31:0]         fuse_data,
    output logic                busy,
    output logic                fuse_rd_en,
    output logic [IDX_W-1:0]    fuse_idx,
    output logic                store_en,
    output logic [IDX_W-1:0]    store_idx,
    output logic [31:0]         store_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

    reload_state_e       state_q, state_d;
    logic [IDX_W-1:0]    idx_q;
    logic [STROBE_W-1:0] cnt_q;
    logic [31:0]         data_q;
    logic                last_word;

    assign last_word = (idx_q == LAST_IDX);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RL_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RL_IDLE:  if (start) state_d = RL_ISSUE;
            RL_ISSUE: state_d = RL_WAIT;
            RL_WAIT:  if (fuse_valid) state_d = (strobe == '0) ? RL_STORE : RL_DWELL;
            RL_DWELL: if (cnt_q <= STROBE_W'(1)) state_d = RL_STORE;
            RL_STORE: state_d = last_word ? RL_IDLE : RL_ISSUE;
            default:  state_d = RL_IDLE;
        endcase
    end

    // Word index, strobe counter and fetched data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            cnt_q  <= '0;
            data_q <= '0;
        end else begin
            if (state_q == RL_IDLE && start)               idx_q <= '0;
            else if (state_q == RL_STORE && !last_word)    idx_q <= idx_q + 1'b1;

            if (state_q == RL_WAIT && fuse_valid)          cnt_q <= strobe;
            else if (state_q == RL_DWELL)                  cnt_q <= cnt_q - 1'b1;

            if (state_q == RL_WAIT && fuse_valid)          data_q <= fuse_data;
        end
    end

    // Outputs
    always_comb begin
        busy       = 1'b1;
        fuse_rd_en = 1'b0;
        store_en   = 1'b0;
        unique case (state_q)
            RL_IDLE:  busy       = 1'b0;
            RL_ISSUE: fuse_rd_en = 1'b1;
            RL_WAIT,
            RL_DWELL: ;
            RL_STORE: store_en   = 1'b1;
            default:  busy       = 1'b0;
        endcase
        fuse_idx   = idx_q;
        store_idx  = idx_q;
        store_data = data_q;
    end

endmodule

// File: rtl/shlk_bus_decode.sv
module shlk_bus_decode
    import shlk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NWORDS = 128,
    parameter int IDX_W  = $clog2(NWORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [31:0] SH_BASE = 32'(OFS_SHADOW);
    localparam logic [31:0] SH_END  = 32'(OFS_SHADOW + (NWORDS << SHADOW_SHIFT));

    logic [31:0] a_ext;
    logic [31:0] sh_off;

    assign a_ext  = 32'(addr);
    assign sh_off = a_ext - SH_BASE;

    always_comb begin
        kind = ACC_NONE;
        idx  = '0;
        if (a_ext == 32'(OFS_CTRL))            kind = ACC_CTRL;
        else if (a_ext == 32'(OFS_CTRL_SET))   kind = ACC_SET;
        else if (a_ext == 32'(OFS_CTRL_CLR))   kind = ACC_CLR;
        else if (a_ext == 32'(OFS_TIMING))     kind = ACC_TIMING;
        else if (a_ext >= SH_BASE && a_ext < SH_END &&
                 sh_off[SHADOW_SHIFT-1:0] == '0) begin
            kind = ACC_SHADOW;
            idx  = IDX_W'(sh_off >> SHADOW_SHIFT);
        end
    end

endmodule

// File: rtl/shlk_lock_table.sv
module shlk_lock_table #(
    parameter int NWORDS = 128,
    parameter int IDX_W  = $clog2(NWORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [31:0]      load_word,
    input  logic [IDX_W-1:0] query_idx,
    output logic             rd_locked,
    output logic             wr_locked
);

    localparam int NGROUPS     = 16;
    localparam int GROUP_WORDS = NWORDS / NGROUPS;
    localparam int GRP_SHIFT   = $clog2(GROUP_WORDS);

    logic [15:0] rd_lock_q;
    logic [15:0] wr_lock_q;
    logic [3:0]  grp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_lock_q <= '0;
            wr_lock_q <= '0;
        end else if (load) begin
            rd_lock_q <= load_word[15:0];
            wr_lock_q <= load_word[31:16];
        end
    end

    assign grp       = 4'(query_idx >> GRP_SHIFT);
    assign rd_locked = rd_lock_q[grp];
    assign wr_locked = wr_lock_q[grp];

endmodule

// File: rtl/shlk_shadow_bank.sv
module shlk_shadow_bank
    import shlk_pkg::*;
#(
    parameter int          NWORDS     = 128,
    parameter int          ADDR_W     = 12,
    parameter int          FUSE_LAT   = 1,
    parameter int          STROBE_W   = 6,
    parameter int          STROBE_RST = 2,
    parameter logic [31:0] LOCK_WORD  = 32'h0024_000A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid
);

    localparam int IDX_W = $clog2(NWORDS);

    acc_kind_e           acc_kind;
    logic [IDX_W-1:0]    acc_idx;
    logic                rd_req, wr_req;
    logic                eng_busy, fuse_rd_en, fuse_valid, store_en;
    logic [IDX_W-1:0]    fuse_idx, store_idx;
    logic [31:0]         fuse_data, store_data;
    logic                rd_locked, wr_locked;
    logic                err_q;
    logic [STROBE_W-1:0] strobe_q;
    logic [31:0]         shadow_q [NWORDS];
    logic                sh_wr_hit, sh_wr_ok, sh_wr_bad, sh_rd_lock;
    logic                err_clr, reload_start;
    logic [31:0]         ctrl_word;

    assign rd_req = bus_sel && !bus_wr;
    assign wr_req = bus_sel && bus_wr;

    shlk_bus_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_dec (
        .addr (bus_addr),
        .kind (acc_kind),
        .idx  (acc_idx)
    );

    shlk_fuse_model #(.NWORDS(NWORDS), .IDX_W(IDX_W), .LAT(FUSE_LAT),
                      .LOCK_WORD(LOCK_WORD)) u_fuse (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (fuse_rd_en),
        .rd_idx   (fuse_idx),
        .rd_valid (fuse_valid),
        .rd_data  (fuse_data)
    );

    shlk_reload_fsm #(.NWORDS(NWORDS), .IDX_W(IDX_W), .STROBE_W(STROBE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (reload_start),
        .strobe     (strobe_q),
        .fuse_valid (fuse_valid),
        .fuse_data  (fuse_data),
        .busy       (eng_busy),
        .fuse_rd_en (fuse_rd_en),
        .fuse_idx   (fuse_idx),
        .store_en   (store_en),
        .store_idx  (store_idx),
        .store_data (store_data)
    );

    shlk_lock_table #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (store_en && store_idx == '0),
        .load_word (store_data),
        .query_idx (acc_idx),
        .rd_locked (rd_locked),
        .wr_locked (wr_locked)
    );

    // Access classification
    assign sh_wr_hit    = wr_req && acc_kind == ACC_SHADOW;
    assign sh_wr_ok     = sh_wr_hit && !eng_busy && !wr_locked;
    assign sh_wr_bad    = sh_wr_hit && (eng_busy || wr_locked);
    assign sh_rd_lock   = rd_req && acc_kind == ACC_SHADOW && rd_locked;
    assign err_clr      = wr_req && acc_kind == ACC_CLR && bus_wdata[CTRL_ERR_BIT];
    assign reload_start = wr_req && acc_kind == ACC_SET && bus_wdata[CTRL_RELOAD_BIT]
                          && !err_q && !eng_busy;

    always_comb begin
        ctrl_word                  = '0;
        ctrl_word[CTRL_BUSY_BIT]   = eng_busy;
        ctrl_word[CTRL_ERR_BIT]    = err_q;
        ctrl_word[CTRL_RELOAD_BIT] = eng_busy;
    end

    // Sticky error and timing register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q    <= 1'b0;
            strobe_q <= STROBE_W'(STROBE_RST);
        end else begin
            if (sh_wr_bad || sh_rd_lock) err_q <= 1'b1;
            else if (err_clr)            err_q <= 1'b0;
            if (wr_req && acc_kind == ACC_TIMING)
                strobe_q <= bus_wdata[STROBE_W-1:0];
        end
    end

    // Shadow storage: the reload engine and bus writes never overlap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NWORDS; k++) shadow_q[k] <= '0;
        end else if (store_en) begin
            shadow_q[store_idx] <= store_data;
        end else if (sh_wr_ok) begin
            shadow_q[acc_idx] <= bus_wdata;
        end
    end

    // Registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_req;
            if (rd_req) begin
                unique case (acc_kind)
                    ACC_CTRL, ACC_SET, ACC_CLR: bus_rdata <= ctrl_word;
                    ACC_TIMING: bus_rdata <= 32'(strobe_q);
                    ACC_SHADOW: bus_rdata <= rd_locked ? LOCKED_MARKER : shadow_q[acc_idx];
                    default:    bus_rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/shlk_shadow_bank_chk.sv
module shlk_shadow_bank_chk
    import shlk_pkg::*;
#(
    parameter int NWORDS = 128,
    parameter int IDX_W  = $clog2(NWORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [31:0]      bus_rdata,
    input logic             bus_rvalid,
    input logic             eng_busy,
    input logic             err_q,
    input logic             err_clr,
    input logic             sh_wr_hit,
    input logic             sh_rd_lock,
    input logic             store_en,
    input logic [IDX_W-1:0] store_idx
);

    // R3: the engine only leaves its busy phase right after storing the last word
    a_r3_ends_on_last_word: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_busy) |-> ($past(store_en) && $past(store_idx) == IDX_W'(NWORDS - 1)));

    // R8: a shadow write during a reload raises the error flag
    a_r8_write_in_reload_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_wr_hit && eng_busy) |=> err_q);

    // R10: a read-locked read answers with the marker and the error flag
    a_r10_marker_on_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
        sh_rd_lock |=> (bus_rvalid && bus_rdata == LOCKED_MARKER && err_q));

    // R11: error holds until an explicit clear
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q);

    // R11: no reload starts while the error flag is pending
    a_r11_no_start_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> !$past(err_q));

    // R12: read data strobe follows each read request by one clock
    a_r12_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    a_r12_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

endmodule

bind shlk_shadow_bank shlk_shadow_bank_chk #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .eng_busy   (eng_busy),
    .err_q      (err_q),
    .err_clr    (err_clr),
    .sh_wr_hit  (sh_wr_hit),
    .sh_rd_lock (sh_rd_lock),
    .store_en   (store_en),
    .store_idx  (store_idx)
);

// File: tb/shlk_shadow_bank_tb.sv
module shlk_shadow_bank_tb;

    localparam int          NW    = 128;
    localparam int          LAT   = 1;
    localparam logic [31:0] LOCKW = 32'h0024_000A;
    localparam logic [31:0] MARK  = 32'hBADA_BADA;
    localparam int A_CTRL = 'h000, A_SET = 'h004, A_CLR = 'h008, A_TIM = 'h010, A_SH = 'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    shlk_shadow_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    always #10 clk = ~clk;   // 50 MHz

    int          n_chk = 0, n_fail = 0;
    logic [31:0] mdl [NW];
    bit          lk_valid = 1'b0;
    bit          m_err = 1'b0;

    function automatic logic [31:0] fuse_img(int i);
        return (i == 0) ? LOCKW : 32'hF00D_0000 + 32'(i * 257);
    endfunction
    function automatic bit rlk(int i);
        return lk_valid && LOCKW[i / (NW / 16)];
    endfunction
    function automatic bit wlk(int i);
        return lk_valid && LOCKW[16 + i / (NW / 16)];
    endfunction
    function automatic logic [31:0] ctrl_exp(bit busy, bit err);
        return (32'(busy) << 8) | (32'(err) << 9) | (32'(busy) << 10);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(int a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'(a);
        @(negedge clk);
        bus_sel = 1'b0;
        if (bus_rvalid !== 1'b1) begin
            n_chk++; n_fail++;
            $display("FAIL R12: rvalid actual %b expected 1", bus_rvalid);
        end
        d = bus_rdata;
    endtask

    task automatic sh_read_check(int i, string req);
        logic [31:0] d, e;
        e = rlk(i) ? MARK : mdl[i];
        if (rlk(i)) m_err = 1'b1;
        bread(A_SH + 16 * i, d);
        check(req, d, e);
    endtask

    task automatic sh_write(int i, logic [31:0] d);
        bwrite(A_SH + 16 * i, d);
        if (wlk(i)) m_err = 1'b1;
        else        mdl[i] = d;
    endtask

    task automatic ctrl_check(string req);
        logic [31:0] d;
        bread(A_CTRL, d);
        check(req, d, ctrl_exp(1'b0, m_err));
    endtask

    task automatic clr_err();
        bwrite(A_CLR, 32'h200);
        m_err = 1'b0;
    endtask

    // Start a reload and poll the control word every cycle until BUSY drops.
    task automatic reload_and_time(output int n);
        int mism;
        mism = 0;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'(A_SET); bus_wdata = 32'h400;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 12'(A_CTRL);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (bus_rdata[8] !== bus_rdata[10]) mism++;
        end while (!(bus_rvalid && bus_rdata[8] == 1'b0) && n < 50000);
        bus_sel = 1'b0;
        check("R3 reload bit tracks busy", 32'(mism), 32'd0);
        for (int k = 0; k < NW; k++) mdl[k] = fuse_img(k);
        lk_valid = 1'b1;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        int guard;
        guard = 0;
        do begin
            bread(A_CTRL, d);
            guard++;
        end while (d[8] && guard < 20000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n0, n5;
        void'($urandom(32'd2024));
        for (int k = 0; k < NW; k++) mdl[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bread(A_CTRL, d);  check("R1 ctrl", d, 32'h0);
        bread(A_TIM, d);   check("R1 timing", d, 32'd2);
        sh_read_check(9, "R1 shadow before reload unlocked");
        sh_read_check(NW - 1, "R1 last shadow zero");
        // R6: no locks before the first reload, so a group 2 write lands
        sh_write(16, 32'h1234_5678);
        sh_read_check(16, "R6 no lock before reload");
        ctrl_check("R1 no error");

        // R2: aliases, unmapped and misaligned reads
        bread(A_SET, d);         check("R2 set alias reads ctrl", d, 32'h0);
        bread('h3F0, d);         check("R2 unmapped", d, 32'h0);
        bread(A_SH + 4, d);      check("R2 misaligned shadow", d, 32'h0);
        bread(A_SH + 16 * NW, d); check("R2 past last shadow", d, 32'h0);

        // R5: timing with strobe 0 and 5
        bwrite(A_TIM, 32'd0);
        bread(A_TIM, d);         check("R2 timing write", d, 32'd0);
        reload_and_time(n0);
        check("R5 reload duration", 32'(n0), 32'(NW * (LAT + 2) + 1));
        bwrite(A_TIM, 32'd5);
        reload_and_time(n5);
        check("R5 strobe adds NWORDS per unit", 32'(n5 - n0), 32'(NW * 5));

        // R3/R4: full image after reload
        for (int k = 0; k < NW; k++) sh_read_check(k, "R4 fuse image");
        ctrl_check("R10 locked reads set error");
        clr_err();
        ctrl_check("R11 clear alias");

        // R7: unlocked write, error untouched
        sh_write(33, 32'hCAFE_0033);
        sh_read_check(33, "R7 unlocked write");
        ctrl_check("R7 error unchanged");
        // R6: overwriting the lock shadow does not change locks
        sh_write(0, 32'h0);
        sh_read_check(0, "R6 lock shadow writable");
        sh_write(40, 32'hFFFF_FFFF);
        sh_read_check(40, "R9 write-locked unchanged");
        ctrl_check("R9 error set");
        clr_err();
        sh_read_check(12, "R10 marker");
        ctrl_check("R10 error set");

        // R11: reload refused while error pending; set alias bit 9 and base writes ignored
        bwrite(A_SET, 32'h400);
        bread(A_CTRL, d);        check("R11 reload refused", d, ctrl_exp(1'b0, 1'b1));
        sh_read_check(0, "R11 shadows untouched by refused reload");
        clr_err();
        bwrite(A_SET, 32'h200);
        ctrl_check("R11 set alias bit 9 ignored");
        bwrite(A_CTRL, 32'hFFFF_FFFF);
        ctrl_check("R11 base write ignored");

        // R8: writes colliding with an active reload
        bwrite(A_TIM, 32'd1);
        bwrite(A_SET, 32'h400);
        bread(A_CTRL, d);        check("R3 busy after start", d, ctrl_exp(1'b1, 1'b0));
        bwrite(A_SH + 16 * 50, 32'hDEAD_0050);
        bwrite(A_SH + 16 * 0,  32'hDEAD_0000);
        bwrite(A_SH + 16 * (NW - 1), 32'hDEAD_007F);
        wait_idle();
        for (int k = 0; k < NW; k++) mdl[k] = fuse_img(k);
        m_err = 1'b1;
        ctrl_check("R8 error after collision");
        sh_read_check(50, "R8 shadow keeps reload value");
        sh_read_check(0, "R8 lock shadow restored");
        sh_read_check(NW - 1, "R8 last shadow from fuse");
        clr_err();

        // Random mix of accesses with locks active
        for (int it = 0; it < 400; it++) begin
            int i;
            i = int'($urandom_range(0, NW - 1));
            if ($urandom_range(0, 1) == 1) sh_write(i, $urandom);
            else sh_read_check(i, "R7/R10 random read");
            if (it % 25 == 24) begin
                ctrl_check("R9/R10/R11 random error state");
                clr_err();
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule